// File: doc/BRIEF.md
# Segmental Bus-Invert Codec for a 40-bit Instruction Bus

This block lowers the number of wire toggles on a 40-bit instruction data bus. A few disjoint bit segments of the word, each of its own width, are coded on their own: for every transfer the encoder counts how many lines of a segment would change against the value last driven there. When more than half of them would change, it drives the complement of that segment and raises that segment's invert line. Bits that lie in no segment are not coded and pass straight through.

The encoder registers the coded word and the invert lines. It loads them only on cycles where the input is marked valid. The first word after reset is driven as it is and becomes the starting bus state. The decoder sits at the far end of the bus. It is purely combinational: it flips each received segment wherever its invert line is high, which gives back the original word. Segment positions and widths are elaboration-time parameters. The defaults place an 8-bit segment over the opcode field (bits 39:32), a 5-bit segment inside the source-register field (bits 30:26) and a 6-bit segment in the immediate field (bits 5:0). Segment lists that overlap, that run past bit 39, or that hold a segment narrower than 2 bits stop elaboration.

Top module: `sbi_codec`

## Requirements
- R1: For each segment after the first word, the encoder counts the bits in which the new input differs from the segment value currently on the bus. This is the coded value, not the previous input. The segment is driven complemented, with its invert line at 1, exactly when twice that count exceeds the segment width.
- R2: When the count is exactly half the segment width, the segment is driven uncomplemented and its invert line is 0.
- R3: Each segment decides on its own and has its own invert line: busInv[0] belongs to bits 39:32, busInv[1] to bits 30:26 and busInv[2] to bits 5:0 with the default parameters.
- R4: Bits outside every segment (31, 25:6 by default) appear on busWord equal to the input word.
- R5: The first valid word after reset is driven unchanged, with all invert lines at 0.
- R6: busWord and busInv change only on a rising clock edge where inValid is 1. They appear one cycle after the word is presented, and they hold while inValid is 0.
- R7: Active-low reset clears busWord and busInv to 0.
- R8: decWord equals rxWord with every segment XORed with its invert line from rxInv, and with the other bits unchanged. When the decoder is fed from the encoder, decWord equals the last valid input word.
- R9: On every transfer after the first, the toggles of a coded segment plus its invert line never exceed the uncoded segment's toggles plus one. The coded segment data alone toggles on at most floor(width/2) lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input word is valid this cycle |
| inWord | input | 40 | Word to send |
| busWord | output | 40 | Coded bus word (registered) |
| busInv | output | NSEG (3) | Invert line per segment (registered) |
| rxWord | input | 40 | Received bus word at the decoder |
| rxInv | input | NSEG (3) | Received invert lines at the decoder |
| decWord | output | 40 | Decoded word |

## Verification
The bench targets the exact-half tie on the even 8-bit and 6-bit segments. A design that inverted on a tie would raise busInv[0] or busInv[2] with no saving. It also checks the odd 5-bit segment, where three changes out of five must invert. It then resends data that matches the previous input but not the complemented bus value, which catches a design that compares against the raw previous input. Passthrough bits, hold while invalid, the plain first word both after reset and after a reset in mid-stream, direct decoder inputs, and a long random stream with per-segment toggle bounds catch wrong masks, stray updates and a wrongly inverted restore.

// File: rtl/sbi_pkg.sv
package sbi_pkg;
  localparam int WORD_W = 40;
  localparam int DEF_NSEG = 3;
  localparam int DEF_LSB [DEF_NSEG] = '{32, 26, 0};
  localparam int DEF_WIDTH [DEF_NSEG] = '{8, 5, 6};

  typedef struct packed {
    logic load;   // capture a new coded word this cycle
    logic first;  // word being captured is the first since reset
  } sbiStrobe_t;

  function automatic logic [WORD_W-1:0] segMask(input int lsb, input int w);
    return ((WORD_W'(1) << w) - WORD_W'(1)) << lsb;
  endfunction
endpackage

// File: rtl/sbi_enc_ctl.sv
module sbi_enc_ctl (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  output sbi_pkg::sbiStrobe_t strobe
);
  logic primed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else if (inValid) primed <= 1'b1;
  end

  always_comb begin
    strobe.load  = inValid;
    strobe.first = inValid & ~primed;
  end
endmodule

// File: rtl/sbi_enc_dp.sv
module sbi_enc_dp #(
  parameter int NSEG = sbi_pkg::DEF_NSEG,
  parameter int SEG_LSB [NSEG] = sbi_pkg::DEF_LSB,
  parameter int SEG_WIDTH [NSEG] = sbi_pkg::DEF_WIDTH
) (
  input  logic clk,
  input  logic rstN,
  input  sbi_pkg::sbiStrobe_t strobe,
  input  logic [sbi_pkg::WORD_W-1:0] inWord,
  output logic [sbi_pkg::WORD_W-1:0] busQ,
  output logic [NSEG-1:0] invQ
);
  localparam int W = sbi_pkg::WORD_W;

  logic [NSEG-1:0] invNext;
  logic [W-1:0] flipPart [NSEG];
  logic [W-1:0] flip;

  genvar g;
  for (g = 0; g < NSEG; g++) begin : g_seg
    localparam int SW = SEG_WIDTH[g];
    localparam logic [W-1:0] M = sbi_pkg::segMask(SEG_LSB[g], SEG_WIDTH[g]);
    logic [W-1:0] diff;
    int hd;
    // transitions against the value actually on the bus
    assign diff = (inWord ^ busQ) & M;
    assign hd = $countones(diff);
    assign invNext[g] = ~strobe.first & ((2 * hd) > SW);
    assign flipPart[g] = M & {W{invNext[g]}};
  end

  always_comb begin
    flip = '0;
    for (int k = 0; k < NSEG; k++) flip = flip | flipPart[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busQ <= '0;
      invQ <= '0;
    end else if (strobe.load) begin
      busQ <= inWord ^ flip;
      invQ <= invNext;
    end
  end
endmodule

// File: rtl/sbi_dec.sv
module sbi_dec #(
  parameter int NSEG = sbi_pkg::DEF_NSEG,
  parameter int SEG_LSB [NSEG] = sbi_pkg::DEF_LSB,
  parameter int SEG_WIDTH [NSEG] = sbi_pkg::DEF_WIDTH
) (
  input  logic [sbi_pkg::WORD_W-1:0] rxWord,
  input  logic [NSEG-1:0] rxInv,
  output logic [sbi_pkg::WORD_W-1:0] decWord
);
  localparam int W = sbi_pkg::WORD_W;
  logic [W-1:0] flip;

  always_comb begin
    flip = '0;
    for (int k = 0; k < NSEG; k++)
      flip = flip | (sbi_pkg::segMask(SEG_LSB[k], SEG_WIDTH[k]) & {W{rxInv[k]}});
    decWord = rxWord ^ flip;
  end
endmodule

// File: rtl/sbi_codec.sv
module sbi_codec #(
  parameter int NSEG = sbi_pkg::DEF_NSEG,
  parameter int SEG_LSB [NSEG] = sbi_pkg::DEF_LSB,
  parameter int SEG_WIDTH [NSEG] = sbi_pkg::DEF_WIDTH
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic [39:0] inWord,
  output logic [39:0] busWord,
  output logic [NSEG-1:0] busInv,
  input  logic [39:0] rxWord,
  input  logic [NSEG-1:0] rxInv,
  output logic [39:0] decWord
);
  function automatic bit segsOk();
    for (int i = 0; i < NSEG; i++) begin
      if (SEG_WIDTH[i] < 2) return 1'b0;
      if (SEG_LSB[i] < 0 || SEG_LSB[i] + SEG_WIDTH[i] > sbi_pkg::WORD_W) return 1'b0;
      for (int j = i + 1; j < NSEG; j++)
        if (SEG_LSB[i] < SEG_LSB[j] + SEG_WIDTH[j] && SEG_LSB[j] < SEG_LSB[i] + SEG_WIDTH[i])
          return 1'b0;
    end
    return 1'b1;
  endfunction

  localparam bit SEGS_OK = segsOk();

  if (!SEGS_OK) begin : g_badSegs
    $error("segment list overlaps, leaves the word, or has a segment under 2 bits");
  end

  sbi_pkg::sbiStrobe_t strobe;

  sbi_enc_ctl u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strobe(strobe)
  );

  sbi_enc_dp #(.NSEG(NSEG), .SEG_LSB(SEG_LSB), .SEG_WIDTH(SEG_WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inWord(inWord),
    .busQ(busWord), .invQ(busInv)
  );

  sbi_dec #(.NSEG(NSEG), .SEG_LSB(SEG_LSB), .SEG_WIDTH(SEG_WIDTH)) u_dec (
    .rxWord(rxWord), .rxInv(rxInv), .decWord(decWord)
  );
endmodule

// File: rtl/sbi_codec_chk.sv
module sbi_codec_chk #(
  parameter int NSEG = sbi_pkg::DEF_NSEG,
  parameter int SEG_LSB [NSEG] = sbi_pkg::DEF_LSB,
  parameter int SEG_WIDTH [NSEG] = sbi_pkg::DEF_WIDTH
) (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic [39:0] inWord,
  input logic [39:0] busWord,
  input logic [NSEG-1:0] busInv,
  input logic [39:0] rxWord,
  input logic [NSEG-1:0] rxInv,
  input logic [39:0] decWord
);
  function automatic logic [39:0] coverMask();
    logic [39:0] m = '0;
    for (int k = 0; k < NSEG; k++) m = m | sbi_pkg::segMask(SEG_LSB[k], SEG_WIDTH[k]);
    return m;
  endfunction
  localparam logic [39:0] COVER = coverMask();

  logic seenFirst;
  logic [39:0] lastIn;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenFirst <= 1'b0;
      lastIn <= '0;
    end else if (inValid) begin
      seenFirst <= 1'b1;
      lastIn <= inWord;
    end
  end

  // R4: uncovered bits copy the input
  p_passthru_r4: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ((busWord ^ $past(inWord)) & ~COVER) == '0);

  // R5: first word is plain
  p_first_plain_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !seenFirst) |=> (busInv == '0) && (busWord == $past(inWord)));

  // R6: no change without a valid word
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(busWord) && $stable(busInv));

  // R8: loopback restores the last sent word
  p_roundtrip_r8: assert property (@(posedge clk) disable iff (!rstN)
    (seenFirst && rxWord == busWord && rxInv == busInv) |-> decWord == lastIn);

  genvar g;
  for (g = 0; g < NSEG; g++) begin : g_seg
    localparam logic [39:0] M = sbi_pkg::segMask(SEG_LSB[g], SEG_WIDTH[g]);
    // R9: coded segment toggles bounded by half its width
    p_seg_toggle_r9: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && seenFirst) |=>
        ($countones((busWord ^ $past(busWord)) & M) <= SEG_WIDTH[g] / 2));
  end
endmodule

bind sbi_codec sbi_codec_chk #(.NSEG(NSEG), .SEG_LSB(SEG_LSB), .SEG_WIDTH(SEG_WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord), .busWord(busWord),
  .busInv(busInv), .rxWord(rxWord), .rxInv(rxInv), .decWord(decWord)
);

// File: tb/sbi_codec_tb.sv
module sbi_codec_tb;
  localparam int NS = 3;
  localparam int LSB [NS] = '{32, 26, 0};
  localparam int WID [NS] = '{8, 5, 6};

  logic clk = 0, rstN = 0, inValid = 0;
  logic [39:0] inWord = '0;
  logic [39:0] busWord, decWord, rxW = '0;
  logic [NS-1:0] busInv, rxI = '0;
  logic rxForce = 0;
  int nChecks = 0, nFails = 0;

  // reference state
  logic [39:0] mBus = '0, mLast = '0;
  logic [NS-1:0] mInv = '0;
  bit mPrimed = 0;

  always #4 clk = ~clk;

  sbi_codec u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .busWord(busWord), .busInv(busInv),
    .rxWord(rxForce ? rxW : busWord), .rxInv(rxForce ? rxI : busInv),
    .decWord(decWord)
  );

  function automatic logic [39:0] bm(int s);
    logic [39:0] m = '0;
    for (int b = 0; b < WID[s]; b++) m[LSB[s] + b] = 1'b1;
    return m;
  endfunction

  function automatic logic [39:0] coverAll();
    return bm(0) | bm(1) | bm(2);
  endfunction

  task automatic check(bit ok, string req, logic [39:0] act, logic [39:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; inValid = 0;
    @(negedge clk);
    rstN = 1;
    mBus = '0; mInv = '0; mPrimed = 0; mLast = '0;
    @(negedge clk);
  endtask

  // sends one word, checks coded output, loopback and toggle bound
  task automatic send(logic [39:0] w, string tag);
    logic [39:0] nb;
    logic [NS-1:0] ni;
    logic [39:0] pBus;
    logic [NS-1:0] pInv;
    nb = w; ni = '0;
    if (mPrimed) begin
      for (int s = 0; s < NS; s++) begin
        int d;
        d = $countones((w ^ mBus) & bm(s));
        if (2 * d > WID[s]) begin
          ni[s] = 1'b1;
          nb = nb ^ bm(s);
        end
      end
    end
    pBus = busWord; pInv = busInv;
    inWord = w; inValid = 1;
    @(negedge clk);
    inValid = 0;
    check(busWord == nb, {tag, " R1 R3 bus"}, busWord, nb);
    check(busInv == ni, {tag, " R1 R3 inv"}, 40'(busInv), 40'(ni));
    check(decWord == w, {tag, " R8 loopback"}, decWord, w);
    if (mPrimed) begin
      for (int s = 0; s < NS; s++) begin
        int coded, unc;
        coded = $countones((busWord ^ pBus) & bm(s)) + ((busInv[s] != pInv[s]) ? 1 : 0);
        unc = $countones((w ^ mLast) & bm(s));
        check(coded <= unc + 1, {tag, " R9 toggles"}, 40'(coded), 40'(unc + 1));
      end
    end
    mBus = nb; mInv = ni; mLast = w; mPrimed = 1;
  endtask

  task automatic t_reset();
    doReset();
    check(busWord == '0, "R7 reset bus", busWord, '0);
    check(busInv == '0, "R7 reset inv", 40'(busInv), '0);
  endtask

  task automatic t_first();
    send(40'hFF_FFFF_FFFF, "R5 first");
    check(busInv == '0, "R5 first plain", 40'(busInv), '0);
  endtask

  task automatic t_ties();
    doReset();
    send(40'h0, "R5 zero first");
    // seg0: 4 of 8 (tie), seg1: 3 of 5, seg2: 3 of 6 (tie)
    send(40'h0F_1C00_0007, "R2 tie");
    check(busInv == 3'b010, "R2 tie inv lines", 40'(busInv), 40'h2);
    // same data again: against coded seg1 value all 5 differ -> invert again
    send(40'h0F_1C00_0007, "R1 stored value");
    check(busInv[1] == 1'b1, "R1 compare coded value", 40'(busInv), 40'h2);
  endtask

  task automatic t_passthru();
    logic [39:0] w;
    w = mLast ^ ~coverAll();
    send(w, "R4");
    check(((busWord ^ w) & ~coverAll()) == '0, "R4 passthrough", busWord, w);
  endtask

  task automatic t_hold();
    logic [39:0] b;
    logic [NS-1:0] iv;
    b = busWord; iv = busInv;
    inWord = ~mLast;
    repeat (3) @(negedge clk);
    check(busWord == b, "R6 hold bus", busWord, b);
    check(busInv == iv, "R6 hold inv", 40'(busInv), 40'(iv));
  endtask

  task automatic t_random();
    for (int i = 0; i < 60; i++) begin
      logic [39:0] w;
      w = {8'($urandom), 32'($urandom)};
      if (i % 4 == 1) w = ~mLast ^ (40'h1 << (i % 40));
      send(w, "R3 stream");
    end
  endtask

  task automatic t_decoder();
    logic [39:0] e;
    rxForce = 1;
    rxW = 40'h12_3456_789A;
    rxI = 3'b101;
    #1;
    e = rxW ^ bm(0) ^ bm(2);
    check(decWord == e, "R8 direct decode", decWord, e);
    rxI = 3'b000;
    #1;
    check(decWord == rxW, "R8 no invert", decWord, rxW);
    rxForce = 0;
    @(negedge clk);
  endtask

  task automatic t_midReset();
    send(40'h55_AAAA_5555, "R3 pre-reset");
    doReset();
    check(busWord == '0 && busInv == '0, "R7 mid reset", busWord, '0);
    send(40'hFF_FFFF_FFFF, "R5 after reset");
    check(busWord == 40'hFF_FFFF_FFFF, "R5 plain again", busWord, 40'hFF_FFFF_FFFF);
  endtask

  initial begin
    t_reset();
    t_first();
    t_ties();
    t_passthru();
    t_hold();
    t_random();
    t_decoder();
    t_midReset();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule